// File: doc/BRIEF.md
# Refresh Row Address Sequencer

This block produces the row address used by DRAM refresh cycles. A 9-bit counter walks through all 512 row values in a fixed pseudo-random order. It moves one step each time the bus side reports, with a one-cycle strobe, that a refresh cycle has completed. Between strobes the counter holds its value, however long the gap. Turning refresh off elsewhere leaves the counter untouched, so the walk resumes from the same row.

Beside the raw counter, the block builds a 20-bit physical address. That address is made from a programmable 7-bit region field that selects the memory area, three constant zero bits, the nine counter bits, and a constant one in the least significant position. The region field is written through a simple write-enable/data port. Request timing and bus arbitration belong to other blocks.

Top module: `rfsh_row_seq`

## Requirements
- R1: While rst_ni is low, and after any reset, the counter is 9'h000, the region field is 7'h00, and rfsh_addr_o is 20'h00001.
- R2: On a clock edge with adv_i high, counter bits 0..5 take the old values of bits 1..6 (bit k receives old bit k+1).
- R3: On an advance where old bits 1..6 are not all ones, new bit 6 is the XNOR of (bit0 XOR bit1) with (bit2 XOR bit3), taken from the old value.
- R4: On an advance where old bits 1..6 are all ones, new bit 6 is the inverse of old bit 0 (old low seven bits 7'h7E go to 7'h7F, and 7'h7F go to 7'h3F).
- R5: The two-bit field in counter bits 8:7 increments by one, modulo 4, on an advance only when the old low seven bits equal 7'h7E (bit 0 clear, bits 1..6 set). On every other advance it holds.
- R6: From the reset seed, 512 advances visit 512 distinct counter values and bring the counter back to 9'h000.
- R7: rfsh_addr_o bit 0 is 1, bits 9:1 equal the counter, bits 12:10 are 0, and bits 19:13 equal the region field.
- R8: A clock edge with region_we_i high loads region_d_i into the region field, which appears on rfsh_addr_o[19:13] after that edge. A region write leaves the counter unchanged.
- R9: On a clock edge with adv_i low, the counter keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| adv_i | input | 1 | One-cycle pulse: a refresh cycle finished, step the counter |
| region_we_i | input | 1 | Write strobe for the region field |
| region_d_i | input | 7 | New region field value |
| rfsh_addr_o | output | 20 | Full physical refresh address |
| row_cnt_o | output | 9 | Raw row counter value |

## Verification
The bench builds the block with its default widths: a seven-bit shift section, a two-bit carry stage and a seven-bit region field. With these widths one whole period is only 512 advances, so the bench can sweep it completely. The sweep passes every all-ones fix-up and all four carry steps, and ends back at the seed. Because the same period also shows that no value repeats, the full-period claim is checked directly rather than inferred from a few sample steps.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;
  localparam int unsigned ROW_LO_W = 7;
  localparam int unsigned ROW_HI_W = 2;
  localparam int unsigned ROW_W    = ROW_LO_W + ROW_HI_W;
  localparam int unsigned GAP_W    = 3;
  localparam int unsigned REGION_W = 7;
  localparam int unsigned ADDR_W   = 1 + ROW_W + GAP_W + REGION_W;
endpackage

// File: rtl/rfsh_row_ctr.sv
module rfsh_row_ctr #(
  parameter int unsigned LO_W = rfsh_pkg::ROW_LO_W,
  parameter int unsigned HI_W = rfsh_pkg::ROW_HI_W,
  localparam int unsigned CW  = LO_W + HI_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          adv_i,
  output logic [CW-1:0] cnt_o
);
  logic [LO_W-1:0] lo_q, lo_d;
  logic [HI_W-1:0] hi_q, hi_d;
  logic            top_ones, wrap_pat, fb;

  assign top_ones = &lo_q[LO_W-1:1];
  assign wrap_pat = top_ones & ~lo_q[0];
  // lockup fix: leave the all-ones state of the xnor register
  assign fb = top_ones ? ~lo_q[0] : ~(lo_q[0] ^ lo_q[1] ^ lo_q[2] ^ lo_q[3]);

  for (genvar i = 0; i < LO_W - 1; i++) begin : g_shift
    assign lo_d[i] = lo_q[i+1];
  end
  assign lo_d[LO_W-1] = fb;
  assign hi_d = wrap_pat ? hi_q + 1'b1 : hi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q <= '0;
      hi_q <= '0;
    end else if (adv_i) begin
      lo_q <= lo_d;
      hi_q <= hi_d;
    end
  end

  assign cnt_o = {hi_q, lo_q};

  assert_shift_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i |=> cnt_o[LO_W-2:0] == $past(cnt_o[LO_W-1:1]));
  assert_fix_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && (&cnt_o[LO_W-1:1])) |=> cnt_o[LO_W-1] == !$past(cnt_o[0]));
  assert_carry_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !(&cnt_o[LO_W-1:1] && !cnt_o[0])) |=> $stable(cnt_o[CW-1:LO_W]));
  assert_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> $stable(cnt_o));
endmodule

// File: rtl/rfsh_region_reg.sv
module rfsh_region_reg #(
  parameter int unsigned RW = rfsh_pkg::REGION_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [RW-1:0] d_i,
  output logic [RW-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (we_i) q_o <= d_i;
  end

  assert_wr_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> q_o == $past(d_i));
  assert_keep_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(q_o));
endmodule

// File: rtl/rfsh_addr_fmt.sv
module rfsh_addr_fmt #(
  parameter int unsigned CW  = rfsh_pkg::ROW_W,
  parameter int unsigned GW  = rfsh_pkg::GAP_W,
  parameter int unsigned RW  = rfsh_pkg::REGION_W,
  localparam int unsigned AW = 1 + CW + GW + RW
) (
  input  logic [CW-1:0] cnt_i,
  input  logic [RW-1:0] region_i,
  output logic [AW-1:0] addr_o
);
  assign addr_o = {region_i, {GW{1'b0}}, cnt_i, 1'b1};
endmodule

// File: rtl/rfsh_row_seq.sv
module rfsh_row_seq
  import rfsh_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                adv_i,
  input  logic                region_we_i,
  input  logic [REGION_W-1:0] region_d_i,
  output logic [ADDR_W-1:0]   rfsh_addr_o,
  output logic [ROW_W-1:0]    row_cnt_o
);
  logic [REGION_W-1:0] region_q;

  rfsh_row_ctr #(.LO_W(ROW_LO_W), .HI_W(ROW_HI_W)) u_ctr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .adv_i (adv_i),
    .cnt_o (row_cnt_o)
  );

  rfsh_region_reg #(.RW(REGION_W)) u_region (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .we_i  (region_we_i),
    .d_i   (region_d_i),
    .q_o   (region_q)
  );

  rfsh_addr_fmt #(.CW(ROW_W), .GW(GAP_W), .RW(REGION_W)) u_fmt (
    .cnt_i   (row_cnt_o),
    .region_i(region_q),
    .addr_o  (rfsh_addr_o)
  );

  assert_addr_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rfsh_addr_o[ROW_W:1] == row_cnt_o && rfsh_addr_o[0]);
  assert_region_cnt_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (region_we_i && !adv_i) |=> $stable(row_cnt_o));
endmodule

// File: tb/rfsh_row_seq_test.sv
module rfsh_row_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        adv = 1'b0;
  logic        we = 1'b0;
  logic [6:0]  rd = '0;
  logic [19:0] addr;
  logic [8:0]  cnt;
  int          total = 0;
  int          bad = 0;
  int          cycles = 0;

  always #2 clk = ~clk;

  rfsh_row_seq uut (
    .clk_i(clk), .rst_ni(rst_n), .adv_i(adv), .region_we_i(we),
    .region_d_i(rd), .rfsh_addr_o(addr), .row_cnt_o(cnt)
  );

  // {adv, we, data[6:0], exp_cnt[8:0], exp_region[6:0]}
  localparam int NV = 9;
  localparam logic [24:0] VEC [NV] = '{
    {1'b1, 1'b0, 7'h00, 9'h040, 7'h00},
    {1'b0, 1'b1, 7'h55, 9'h040, 7'h55},
    {1'b1, 1'b0, 7'h00, 9'h060, 7'h55},
    {1'b1, 1'b1, 7'h2A, 9'h070, 7'h2A},
    {1'b0, 1'b0, 7'h11, 9'h070, 7'h2A},
    {1'b1, 1'b0, 7'h00, 9'h078, 7'h2A},
    {1'b1, 1'b0, 7'h00, 9'h03C, 7'h2A},
    {1'b1, 1'b0, 7'h00, 9'h05E, 7'h2A},
    {1'b1, 1'b0, 7'h00, 9'h02F, 7'h2A}
  };

  function automatic logic [8:0] model_next(input logic [8:0] c);
    logic [6:0] lo;
    logic [1:0] hi;
    logic       nb;
    lo = c[6:0];
    hi = c[8:7];
    if (&lo[6:1]) nb = ~lo[0];
    else          nb = (lo[0] ^ lo[1]) ~^ (lo[2] ^ lo[3]);
    if (lo == 7'h7E) hi = hi + 2'd1;
    return {hi, nb, lo[6:1]};
  endfunction

  function automatic logic [19:0] mk_addr(input logic [6:0] r, input logic [8:0] c);
    return {r, 3'b000, c, 1'b1};
  endfunction

  task automatic chk(input string req, input logic [19:0] act, input logic [19:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // entered at a negedge; applies inputs across one posedge
  task automatic tick(input logic a, input logic w, input logic [6:0] d);
    adv = a; we = w; rd = d;
    @(negedge clk);
    adv = 1'b0; we = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    #1;
    chk("R1 cnt in reset", {11'd0, cnt}, 20'd0);
    chk("R1 addr in reset", addr, 20'h00001);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin : watchdog
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        bad++;
        total++;
        $display("FAIL watchdog act=%0d exp<=20000", cycles);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin : main
    logic [8:0] exp_c;
    logic [8:0] prev;
    bit         seen [512];
    int         distinct;
    @(negedge clk);
    do_reset();
    chk("R1 after reset", addr, 20'h00001);

    // table walk: R2 R3 R7 R8 R9
    for (int i = 0; i < NV; i++) begin
      tick(VEC[i][24], VEC[i][23], VEC[i][22:16]);
      chk("R2/R3/R9 table cnt", {11'd0, cnt}, {11'd0, VEC[i][15:7]});
      chk("R7/R8 table addr", addr, mk_addr(VEC[i][6:0], VEC[i][15:7]));
    end

    // long idle gap: R9
    repeat (37) @(negedge clk);
    chk("R9 idle hold", {11'd0, cnt}, 20'h0002F);

    // async reset mid-run clears counter and region: R1
    do_reset();
    chk("R1 region cleared", addr, 20'h00001);

    // full period sweep: R3 R4 R5 R6
    for (int k = 0; k < 512; k++) seen[k] = 1'b0;
    distinct = 0;
    exp_c = 9'h000;
    for (int k = 0; k < 512; k++) begin
      if (!seen[cnt]) distinct++;
      seen[cnt] = 1'b1;
      prev = cnt;
      exp_c = model_next(exp_c);
      tick(1'b1, 1'b0, 7'h00);
      if (cnt !== exp_c) begin
        total++; bad++;
        $display("FAIL R3 sweep step %0d act=%h exp=%h", k, cnt, exp_c);
      end
      if (prev[6:0] == 7'h7E) begin
        chk("R4 7E->7F", {13'd0, cnt[6:0]}, 20'h7F);
        chk("R5 carry step", {18'd0, cnt[8:7]}, {18'd0, prev[8:7] + 2'd1});
      end
      if (prev[6:0] == 7'h7F)
        chk("R4 7F->3F", {13'd0, cnt[6:0]}, 20'h3F);
    end
    total++;
    chk("R6 distinct count", 20'(distinct), 20'd512);
    total--;
    chk("R6 back to seed", {11'd0, cnt}, 20'd0);

    // region write during no advance keeps counter: R8
    tick(1'b1, 1'b0, 7'h00);
    tick(1'b0, 1'b1, 7'h7F);
    chk("R8 region max", addr, mk_addr(7'h7F, 9'h040));

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule